// File: doc/BRIEF.md
# Branch Resolver with Likely Nullification

This block decides the outcome of control-transfer instructions for a single-issue pipeline that has one architectural delay slot. For every instruction it accepts, it reports whether control transfers, whether the following delay-slot instruction must be squashed, whether a return address is written to a register, and which PC the pipeline should fetch next.

Decoded instructions arrive on a valid/ready stream. Each carries a condition kind, two 32-bit register operands, a 5-bit bit-number immediate, the instruction's own PC, an already computed target address, and a destination index for jump-and-link. Results leave through one registered output stage with its own valid/ready pair. An input is accepted when `in_valid` and `in_ready` are both high, and `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new input is taken.

A taken transfer does not redirect at once. The instruction after it, the delay slot, is still fetched from PC+4, and the target is held in a one-entry pending register. It is handed out as the next PC of the following accepted instruction. The pipeline presents the slot to this block even when it squashes the slot.

Top module: `branch_resolver`

## Requirements
- R1: Kind 1 (bit test, immediate) is taken when bit `in_bitnum` of `in_rs` is 1. Kind 2 (negated) is taken when that bit is 0. Bit 31 is included.
- R2: Kind 3 (bit test, variable) and kind 4 (its negated form) take the bit number from `in_rt[4:0]`. Bits 31:5 of `in_rt` have no effect.
- R3: Kind 5 is taken when `in_rs` is greater than zero, read as a signed value. Kind 6 is taken when `in_rs` is zero or negative.
- R4: Kind 7 is taken when at least one of the four byte lanes of `in_rs` equals the same lane of `in_rt`.
- R5: Kind 8 (jump) and kind 9 (jump-and-link) are always taken. Kind 0 (no control transfer) is never taken.
- R6: `out_nullify` is 1 only for a conditional kind (1 to 7) that has `in_likely` set and is not taken. A non-likely branch that is not taken leaves the slot alone.
- R7: A conditional kind with `in_link` set writes PC+8 to register 31 only when it is taken. When it is not taken, `out_link_we` stays 0.
- R8: Kind 9 writes PC+8 to register `in_dest`. The write is suppressed when `in_dest` is 0.
- R9: `out_next_pc` is the entry's PC+4, unless the previously accepted entry was taken. In that case it is that entry's target.
- R10: While `out_valid` is 1 and `out_ready` is 0, all outputs are stable and `in_ready` is 0.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and no target is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input entry valid |
| in_ready | output | 1 | Block can accept an entry |
| in_kind | input | 4 | Condition kind (0 to 9, see R1 to R5) |
| in_likely | input | 1 | Squash the delay slot when not taken |
| in_link | input | 1 | Conditional branch also links to register 31 |
| in_rs | input | 32 | First register operand |
| in_rt | input | 32 | Second register operand |
| in_bitnum | input | 5 | Bit-number immediate |
| in_pc | input | 32 | PC of this entry |
| in_target | input | 32 | Transfer target |
| in_dest | input | 5 | Link register index for jump-and-link |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_taken | output | 1 | Control transfers |
| out_nullify | output | 1 | Squash the delay slot |
| out_next_pc | output | 32 | PC to fetch next |
| out_link_we | output | 1 | Write the link register |
| out_link_idx | output | 5 | Link register index |
| out_link_data | output | 32 | Return address (PC+8) |

## Verification
Two functions can land in the same entry. First, the redirect to a pending target can coincide with the delay-slot entry's own decision. Second, the link write is reported in the same result as the taken decision. The bench provokes the first case by issuing a taken branch and then a delay-slot entry, and checks that this entry's next PC is the earlier target while its own taken, nullify and link fields follow its own operands. The bench provokes the second case with linking conditional branches in both outcomes, and checks that the write appears only alongside a taken flag.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int XLEN  = 32;
  localparam int RIDX  = 5;
  localparam int KINDW = 4;

  typedef enum logic [KINDW-1:0] {
    K_NONE   = 4'd0,
    K_BITI   = 4'd1,
    K_BITI_N = 4'd2,
    K_BITV   = 4'd3,
    K_BITV_N = 4'd4,
    K_GTZ    = 4'd5,
    K_LEZ    = 4'd6,
    K_BYTEEQ = 4'd7,
    K_JUMP   = 4'd8,
    K_JLINK  = 4'd9
  } br_kind_e;

  function automatic logic is_cond(input logic [KINDW-1:0] k);
    return (k >= 4'd1) && (k <= 4'd7);
  endfunction
endpackage

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [KINDW-1:0]      kind,
  input  logic [W-1:0]          rs,
  input  logic [W-1:0]          rt,
  input  logic [$clog2(W)-1:0]  bitnum,
  output logic                  taken
);
  localparam int LANES = W / 8;
  localparam int SELW  = $clog2(W);

  logic [LANES-1:0] lane_eq;
  logic             imm_bit, var_bit, gtz;
  logic [SELW-1:0]  var_sel;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (rs[g*8 +: 8] == rt[g*8 +: 8]);
    end
  endgenerate

  assign var_sel = rt[SELW-1:0];
  assign imm_bit = rs[bitnum];
  assign var_bit = rs[var_sel];
  assign gtz     = ($signed(rs) > 0);

  always_comb begin
    unique case (kind)
      K_BITI:   taken = imm_bit;
      K_BITI_N: taken = !imm_bit;
      K_BITV:   taken = var_bit;
      K_BITV_N: taken = !var_bit;
      K_GTZ:    taken = gtz;
      K_LEZ:    taken = !gtz;
      K_BYTEEQ: taken = |lane_eq;
      K_JUMP,
      K_JLINK:  taken = 1'b1;
      default:  taken = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == K_BYTEEQ && rs == rt)
      assert_lane_all_R4: assert (taken);
  end
endmodule

// File: rtl/br_link.sv
module br_link
  import br_pkg::*;
#(
  parameter int W = XLEN,
  parameter int RW = RIDX
) (
  input  logic [KINDW-1:0] kind,
  input  logic             link,
  input  logic             taken,
  input  logic [W-1:0]     pc,
  input  logic [RW-1:0]    dest,
  output logic             we,
  output logic [RW-1:0]    idx,
  output logic [W-1:0]     data
);
  localparam logic [RW-1:0] RA_IDX = {RW{1'b1}};

  assign data = pc + W'(8);

  always_comb begin
    we  = 1'b0;
    idx = '0;
    if (kind == K_JLINK) begin
      idx = dest;
      we  = (dest != '0);
    end else if (is_cond(kind) && link) begin
      idx = RA_IDX;
      we  = taken;
    end
  end

  always_comb begin
    if (we) assert_link_taken_R7: assert (taken && idx != '0);
  end
endmodule

// File: rtl/br_pc_track.sv
module br_pc_track
  import br_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         taken,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] target,
  output logic [W-1:0] next_pc
);
  logic         pend_v;
  logic [W-1:0] pend_t;

  assign next_pc = pend_v ? pend_t : pc + W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_t <= '0;
    end else if (accept) begin
      pend_v <= taken;
      pend_t <= target;
    end
  end

  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && taken |=> pend_v);
  assert_pend_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> pend_v == $past(pend_v));
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int RW = RIDX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [KINDW-1:0]     in_kind,
  input  logic                 in_likely,
  input  logic                 in_link,
  input  logic [W-1:0]         in_rs,
  input  logic [W-1:0]         in_rt,
  input  logic [$clog2(W)-1:0] in_bitnum,
  input  logic [W-1:0]         in_pc,
  input  logic [W-1:0]         in_target,
  input  logic [RW-1:0]        in_dest,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_taken,
  output logic                 out_nullify,
  output logic [W-1:0]         out_next_pc,
  output logic                 out_link_we,
  output logic [RW-1:0]        out_link_idx,
  output logic [W-1:0]         out_link_data
);
  logic          accept, c_taken, c_null, c_we;
  logic [RW-1:0] c_idx;
  logic [W-1:0]  c_data, c_npc;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign c_null   = is_cond(in_kind) && in_likely && !c_taken;

  br_cond #(.W(W)) u_cond (
    .kind(in_kind), .rs(in_rs), .rt(in_rt), .bitnum(in_bitnum), .taken(c_taken)
  );

  br_link #(.W(W), .RW(RW)) u_link (
    .kind(in_kind), .link(in_link), .taken(c_taken), .pc(in_pc), .dest(in_dest),
    .we(c_we), .idx(c_idx), .data(c_data)
  );

  br_pc_track #(.W(W)) u_pc (
    .clk(clk), .rst_n(rst_n), .accept(accept), .taken(c_taken),
    .pc(in_pc), .target(in_target), .next_pc(c_npc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_taken     <= 1'b0;
      out_nullify   <= 1'b0;
      out_next_pc   <= '0;
      out_link_we   <= 1'b0;
      out_link_idx  <= '0;
      out_link_data <= '0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_taken     <= c_taken;
      out_nullify   <= c_null;
      out_next_pc   <= c_npc;
      out_link_we   <= c_we;
      out_link_idx  <= c_idx;
      out_link_data <= c_data;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc)
      && $stable(out_taken) && $stable(out_nullify) && $stable(out_link_we));
  assert_null_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_nullify && out_taken));
  assert_link_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_link_we |-> out_link_idx != '0 && out_taken);
endmodule

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0, in_ready, in_likely = 1'b0, in_link = 1'b0;
  logic [3:0]  in_kind = '0;
  logic [31:0] in_rs = '0, in_rt = '0, in_pc = '0, in_target = '0;
  logic [4:0]  in_bitnum = '0, in_dest = '0;
  logic        out_valid, out_ready = 1'b1, out_taken, out_nullify, out_link_we;
  logic [31:0] out_next_pc, out_link_data;
  logic [4:0]  out_link_idx;

  int n_chk = 0, n_fail = 0;
  logic        m_pend = 1'b0;
  logic [31:0] m_tgt = '0;

  branch_resolver u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] k, input logic lk, input logic ln,
                      input logic [31:0] rs, input logic [31:0] rt, input logic [4:0] bn,
                      input logic [31:0] pc, input logic [31:0] tg, input logic [4:0] dst,
                      input logic e_tk, input logic e_nl, input logic e_we,
                      input logic [4:0] e_idx, input string tag);
    logic [31:0] e_npc;
    e_npc = m_pend ? m_tgt : pc + 32'd4;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_likely = lk; in_link = ln; in_rs = rs; in_rt = rt;
    in_bitnum = bn; in_pc = pc; in_target = tg; in_dest = dst;
    @(negedge clk);
    in_valid = 1'b0;
    m_pend = e_tk; m_tgt = tg;
    chk(out_taken, e_tk, {tag, " taken"});
    chk(out_nullify, e_nl, {tag, " nullify"});
    chk(out_link_we, e_we, {tag, " link_we"});
    if (e_we) begin
      chk(out_link_idx, e_idx, {tag, " link_idx"});
      chk(out_link_data, pc + 32'd8, {tag, " link_data"});
    end
    chk(out_next_pc, e_npc, {tag, " next_pc R9"});
  endtask

  task automatic t_reset();
    chk(out_valid, 0, "R11 out_valid after reset");
    chk(in_ready, 1, "R11 in_ready after reset");
  endtask

  task automatic t_bit_imm();
    send(1, 0, 0, 32'h8000_0000, 0, 31, 32'h100, 32'h900, 0, 1, 0, 0, 0, "R1 bit31 set");
    send(0, 0, 0, 0, 0, 0, 32'h104, 0, 0, 0, 0, 0, 0, "R9 delay slot");
    send(1, 1, 0, 32'h7FFF_FFFF, 0, 31, 32'h200, 32'h900, 0, 0, 1, 0, 0, "R1 R6 bit31 clear likely");
    send(2, 0, 0, 32'h7FFF_FFFF, 0, 31, 32'h204, 32'h900, 0, 1, 0, 0, 0, "R1 negated taken");
    send(2, 0, 0, 32'h0000_0010, 0, 4, 32'h900, 32'hA00, 0, 0, 0, 0, 0, "R1 negated not taken");
  endtask

  task automatic t_bit_var();
    send(3, 0, 0, 32'h0000_0008, 32'hFFFF_FFE3, 0, 32'h300, 32'h340, 0, 1, 0, 0, 0, "R2 var high rt bits");
    send(4, 1, 0, 32'h0000_0008, 32'h0000_0003, 0, 32'h304, 32'h380, 0, 0, 1, 0, 0, "R2 R6 var negated likely");
    send(3, 0, 0, 32'h8000_0000, 32'h0000_001F, 0, 32'h400, 32'h480, 0, 1, 0, 0, 0, "R2 var bit31");
    send(0, 0, 0, 0, 0, 0, 32'h404, 0, 0, 0, 0, 0, 0, "R9 flush");
  endtask

  task automatic t_signed();
    send(5, 1, 0, 32'h8000_0000, 0, 0, 32'h500, 32'h600, 0, 0, 1, 0, 0, "R3 gtz most negative");
    send(5, 0, 0, 32'h0000_0000, 0, 0, 32'h504, 32'h600, 0, 0, 0, 0, 0, "R3 R6 gtz zero nonlikely");
    send(6, 0, 0, 32'h0000_0000, 0, 0, 32'h508, 32'h700, 0, 1, 0, 0, 0, "R3 lez zero");
    send(6, 0, 0, 32'h8000_0000, 0, 0, 32'h50C, 32'h710, 0, 1, 0, 0, 0, "R3 R9 lez negative in slot");
    send(6, 1, 0, 32'h7FFF_FFFF, 0, 0, 32'h710, 32'h800, 0, 0, 1, 0, 0, "R3 lez max positive");
  endtask

  task automatic t_bytes();
    send(7, 0, 0, 32'hAB11_2233, 32'hAB44_5566, 0, 32'hB00, 32'hC00, 0, 1, 0, 0, 0, "R4 lane3 match");
    send(7, 1, 0, 32'h0102_0304, 32'h1020_3040, 0, 32'hB04, 32'hC00, 0, 0, 1, 0, 0, "R4 no lane match");
    send(7, 0, 0, 32'h1111_1122, 32'h2222_2222, 0, 32'hB08, 32'hC40, 0, 1, 0, 0, 0, "R4 lane0 match");
    send(0, 0, 0, 0, 0, 0, 32'hB0C, 0, 0, 0, 0, 0, 0, "R5 none never taken");
  endtask

  task automatic t_link();
    send(5, 0, 1, 32'h0000_0005, 0, 0, 32'hD00, 32'hE00, 0, 1, 0, 1, 31, "R7 gtz link taken");
    send(6, 1, 1, 32'h0000_0005, 0, 0, 32'hD04, 32'hE00, 0, 0, 1, 0, 0, "R7 lez link not taken");
    send(8, 1, 0, 0, 0, 0, 32'hE00, 32'hF00, 7, 1, 0, 0, 0, "R5 R6 jump likely no nullify");
    send(9, 0, 0, 0, 0, 0, 32'hE04, 32'hF40, 5, 1, 0, 1, 5, "R8 jal dest5");
    send(9, 0, 0, 0, 0, 0, 32'hF40, 32'hF80, 0, 1, 0, 0, 0, "R8 jal dest0 suppressed");
    send(0, 0, 0, 0, 0, 0, 32'hF44, 0, 0, 0, 0, 0, 0, "R9 flush after jal");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_kind = 0; in_likely = 0; in_link = 0; in_pc = 32'h2000;
    @(negedge clk);
    chk(in_ready, 0, "R10 in_ready low while stalled");
    in_pc = 32'h3000;
    repeat (2) @(negedge clk);
    chk(out_valid, 1, "R10 out_valid held");
    chk(out_next_pc, 32'h2004, "R10 output stable");
    chk(in_ready, 0, "R10 still stalled");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_next_pc, 32'h3004, "R10 second entry after release");
    @(negedge clk);
    chk(out_valid, 0, "R10 drained");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bit_imm();
    t_bit_var();
    t_signed();
    t_bytes();
    t_link();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule